// File: doc/BRIEF.md
# Timer with Match and Capture Control

This block is a free-running up-counter paced by a prescaler, with a set of compare channels and a set of edge-sampled capture inputs. Each compare channel watches the count and can, when the count reaches its value, raise a sticky interrupt flag, return the count to zero, or freeze both counters and drop the run bit. These three actions are chosen independently per channel.

Each capture input goes through a two-stage synchronizer. A rising edge, a falling edge, or either edge is chosen per input. The chosen edge copies the current count into that input's capture register and can optionally raise a flag. Software drives everything through a single-cycle write port. The count, the capture registers, the raw compare results, the run bit and the interrupt flags are visible on ports.

Top module: `match_cap_timer`

## Requirements
- R1: After reset the count is 0, run_o is 0, every interrupt flag is 0 and every capture register is 0.
- R2: The control word is at address 0: bit 0 is run and bit 1 is hold-clear. The prescale limit P is at address 1. While run is 1 and hold-clear is 0, the count rises by one every P+1 clocks. The first step lands P+1 clocks after the write that sets run.
- R3: The match control word is at address 2, with 3 bits per channel i at bits 3i+2..3i: bit 3i = flag, bit 3i+1 = clear count, bit 3i+2 = halt. Channel i's value is at address 8+i. With the flag bit set, a match sets irq_o[i]. The flag stays set until a write to address 4 with bit i at 1. With the flag bit clear, irq_o[i] is never set.
- R4: With the clear-count bit set, the count goes to 0 on the step where it equals the channel value, so the count never exceeds that value.
- R5: With the halt bit set, a match freezes the count at the channel value and the run bit reads 0 on the next clock. The count then stays put.
- R6: When one channel clears the count and another halts on the same step, the count is 0 and run is 0, and both flags are set if both are enabled.
- R7: The capture control word is at address 3, with 3 bits per input j: bit 3j = rising, bit 3j+1 = falling, bit 3j+2 = flag. A selected edge on cap_i[j] loads the current count into capture register j (cap_val_o bits 32j+31..32j).
- R8: An edge whose direction is not selected leaves the capture register unchanged.
- R9: With both the rising and the falling bit set, every edge of that input loads the capture register.
- R10: A capture load sets irq_o[N_MATCH+j] only when that input's flag bit is 1.
- R11: With every control bit at its reset value of 0, a count equal to a channel value has no effect on the count, the run bit or the flags.
- R12: While hold-clear is 1, the count is held at 0 even with run at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| cap_i | input | N_CAP | Capture pins, asynchronous |
| tc_o | output | CNT_W | Current count |
| run_o | output | 1 | Run bit |
| cap_val_o | output | N_CAP*CNT_W | Capture registers, input j in bits CNT_W*j upward |
| match_o | output | N_MATCH | Count equals channel value, per channel |
| irq_o | output | N_MATCH+N_CAP | Sticky flags: compare channels low, capture inputs above |

## Verification
Two compare channels can be programmed to the same value, one set to clear the count and the other to halt. Their actions then land on the same prescaler step. The bench provokes this with both channels at 7 and both flag bits set. It judges the outcome at the ports: the count must read 0, the run bit 0, and both flags 1. This proves that the halt dropped the run bit while the clear still zeroed the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } mch_ctl_t;

  typedef struct packed {
    logic irq;
    logic fall;
    logic rise;
  } cap_ctl_t;

  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_PRE   = 1;
  localparam int unsigned ADDR_MCTL  = 2;
  localparam int unsigned ADDR_CCTL  = 3;
  localparam int unsigned ADDR_ICLR  = 4;
  localparam int unsigned ADDR_MATCH = 8;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned N_CAP   = 2,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned N_IRQ  = N_MATCH + N_CAP
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [CNT_W-1:0]                  wr_data_i,
  input  logic                              stop_evt_i,
  output logic                              run_o,
  output logic                              hold_o,
  output logic [CNT_W-1:0]                  pre_o,
  output mch_ctl_t [N_MATCH-1:0]            mctl_o,
  output cap_ctl_t [N_CAP-1:0]              cctl_o,
  output logic [N_MATCH-1:0][CNT_W-1:0]     mval_o,
  output logic [N_IRQ-1:0]                  iclr_o
);
  logic sel_ctrl, sel_pre, sel_mctl, sel_cctl, sel_iclr;
  logic run_q, hold_q;
  logic [CNT_W-1:0] pre_q;
  logic [3*N_MATCH-1:0] mctl_q;
  logic [3*N_CAP-1:0] cctl_q;

  assign sel_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_pre  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_PRE));
  assign sel_mctl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MCTL));
  assign sel_cctl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CCTL));
  assign sel_iclr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_ICLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      pre_q  <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
    end else begin
      if (sel_ctrl) begin
        run_q  <= wr_data_i[0];
        hold_q <= wr_data_i[1];
      end
      // halt from a compare channel wins over a same-cycle write
      if (stop_evt_i) run_q <= 1'b0;
      if (sel_pre)  pre_q  <= wr_data_i;
      if (sel_mctl) mctl_q <= wr_data_i[3*N_MATCH-1:0];
      if (sel_cctl) cctl_q <= wr_data_i[3*N_CAP-1:0];
    end
  end

  for (genvar i = 0; i < N_MATCH; i++) begin : g_mval
    logic sel_m;
    logic [CNT_W-1:0] mval_q;
    assign sel_m = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MATCH + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    mval_q <= '0;
      else if (sel_m) mval_q <= wr_data_i;
    end
    assign mval_o[i] = mval_q;
    assign mctl_o[i] = mch_ctl_t'(mctl_q[3*i +: 3]);
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cctl
    assign cctl_o[j] = cap_ctl_t'(cctl_q[3*j +: 3]);
  end

  assign run_o  = run_q;
  assign hold_o = hold_q;
  assign pre_o  = pre_q;
  assign iclr_o = sel_iclr ? wr_data_i[N_IRQ-1:0] : '0;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_MATCH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic                          hold_i,
  input  logic [CNT_W-1:0]              pre_i,
  input  mch_ctl_t [N_MATCH-1:0]        mctl_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0] mval_i,
  output logic [CNT_W-1:0]              tc_o,
  output logic [N_MATCH-1:0]            match_o,
  output logic [N_MATCH-1:0]            mch_irq_o,
  output logic                          stop_evt_o,
  output logic                          rst_evt_o
);
  logic [CNT_W-1:0] pc_q, tc_q;
  logic tick;
  logic [N_MATCH-1:0] rst_hit, stop_hit;

  // >= guards against a limit lowered below the running prescale count
  assign tick = run_i && !hold_i && (pc_q >= pre_i);

  for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
    logic hit;
    assign match_o[i]   = (tc_q == mval_i[i]);
    assign hit          = tick && match_o[i];
    assign mch_irq_o[i] = hit && mctl_i[i].irq;
    assign rst_hit[i]   = hit && mctl_i[i].rst;
    assign stop_hit[i]  = hit && mctl_i[i].stop;
  end

  assign rst_evt_o  = |rst_hit;
  assign stop_evt_o = |stop_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (hold_i) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        pc_q <= '0;
        if (rst_evt_o)       tc_q <= '0;
        else if (!stop_evt_o) tc_q <= tc_q + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign tc_o = tc_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CAP = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CAP-1:0]            cap_i,
  input  cap_ctl_t [N_CAP-1:0]        cctl_i,
  input  logic [CNT_W-1:0]            tc_i,
  output logic [N_CAP-1:0][CNT_W-1:0] cap_val_o,
  output logic [N_CAP-1:0]            cap_irq_o
);
  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    logic s1_q, s2_q, prev_q, load;
    logic [CNT_W-1:0] val_q;

    assign load = (s2_q && !prev_q && cctl_i[j].rise) ||
                  (!s2_q && prev_q && cctl_i[j].fall);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
        val_q  <= '0;
      end else begin
        s1_q   <= cap_i[j];
        s2_q   <= s1_q;
        prev_q <= s2_q;
        if (load) val_q <= tc_i;
      end
    end

    assign cap_val_o[j] = val_q;
    assign cap_irq_o[j] = load && cctl_i[j].irq;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned N_IRQ = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] set_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] flags_o
);
  logic [N_IRQ-1:0] flags_q;

  // a set in the same cycle as its clear keeps the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/match_cap_timer.sv
module match_cap_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned N_CAP   = 2,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned N_IRQ  = N_MATCH + N_CAP
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  input  logic [N_CAP-1:0]         cap_i,
  output logic [CNT_W-1:0]         tc_o,
  output logic                     run_o,
  output logic [N_CAP*CNT_W-1:0]   cap_val_o,
  output logic [N_MATCH-1:0]       match_o,
  output logic [N_IRQ-1:0]         irq_o
);
  logic hold, stop_evt, rst_evt;
  logic [CNT_W-1:0] pre;
  mch_ctl_t [N_MATCH-1:0] mctl;
  cap_ctl_t [N_CAP-1:0] cctl;
  logic [N_MATCH-1:0][CNT_W-1:0] mval;
  logic [N_IRQ-1:0] iclr;
  logic [N_MATCH-1:0] mch_irq;
  logic [N_CAP-1:0] cap_irq;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;

  tmr_regs #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .stop_evt_i(stop_evt),
    .run_o,
    .hold_o(hold),
    .pre_o(pre),
    .mctl_o(mctl),
    .cctl_o(cctl),
    .mval_o(mval),
    .iclr_o(iclr)
  );

  tmr_count #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_count (
    .clk_i, .rst_ni,
    .run_i(run_o),
    .hold_i(hold),
    .pre_i(pre),
    .mctl_i(mctl),
    .mval_i(mval),
    .tc_o,
    .match_o,
    .mch_irq_o(mch_irq),
    .stop_evt_o(stop_evt),
    .rst_evt_o(rst_evt)
  );

  tmr_capture #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_capture (
    .clk_i, .rst_ni, .cap_i,
    .cctl_i(cctl),
    .tc_i(tc_o),
    .cap_val_o(cap_val),
    .cap_irq_o(cap_irq)
  );

  tmr_irq #(.N_IRQ(N_IRQ)) u_irq (
    .clk_i, .rst_ni,
    .set_i({cap_irq, mch_irq}),
    .clr_i(iclr),
    .flags_o(irq_o)
  );

  for (genvar j = 0; j < N_CAP; j++) begin : g_flat
    assign cap_val_o[j*CNT_W +: CNT_W] = cap_val[j];
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_IRQ  = 6,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  tc_o,
  input logic              run_o,
  input logic [N_IRQ-1:0]  irq_o,
  input logic              stop_evt,
  input logic              rst_evt
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_addr_i == ADDR_W'(tmr_pkg::ADDR_ICLR));

  assert_run_dropped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !run_o);

  assert_tc_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt && !rst_evt) |=> (tc_o == $past(tc_o)));

  assert_tc_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt |=> (tc_o == '0));

  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |=> ((tc_o == $past(tc_o)) || (tc_o == '0)));

  assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> ((tc_o == $past(tc_o)) || (tc_o == $past(tc_o) + 1'b1) || (tc_o == '0)));

  assert_flags_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((irq_o & $past(irq_o)) == $past(irq_o)));
endmodule

bind match_cap_timer tmr_chk #(
  .CNT_W(CNT_W), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .tc_o, .run_o, .irq_o,
  .stop_evt(stop_evt),
  .rst_evt(rst_evt)
);

// File: tb/match_cap_timer_tb.sv
module match_cap_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int N_MATCH = 4;
  localparam int N_CAP = 2;
  localparam int ADDR_W = 5;
  localparam int N_IRQ = N_MATCH + N_CAP;

  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_PRE = 1, A_MCTL = 2, A_CCTL = 3,
                                A_ICLR = 4, A_M0 = 8;

  // prescale limit, clocks waited after run, expected count
  localparam int PRE_TAB [0:4][0:2] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 10, 3}, '{3, 9, 2}, '{4, 25, 5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [N_CAP-1:0] cap = '0;
  logic [CNT_W-1:0] tc;
  logic run;
  logic [N_CAP*CNT_W-1:0] cap_val;
  logic [N_MATCH-1:0] match;
  logic [N_IRQ-1:0] irq;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_cap_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cap_i(cap), .tc_o(tc), .run_o(run),
    .cap_val_o(cap_val), .match_o(match), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run from zero and halt on channel 0 at value v
  task automatic halt_at(input int v);
    wr(A_CTRL, 2);
    wr(A_M0, v);
    wr(A_MCTL, 5);
    wr(A_PRE, 0);
    wr(A_CTRL, 1);
    wait_clk(v + 10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int mx;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);

    // R1 reset state
    chk("R1 tc", tc, 0);
    chk("R1 run", {31'b0, run}, 0);
    chk("R1 irq", {26'b0, irq}, 0);
    chk("R1 cap0", cap_val[31:0], 0);
    chk("R1 cap1", cap_val[63:32], 0);

    // R2 prescale table
    for (int k = 0; k < 5; k++) begin
      wr(A_CTRL, 2);
      wr(A_PRE, PRE_TAB[k][0]);
      wr(A_CTRL, 1);
      wait_clk(PRE_TAB[k][1]);
      chk("R2 prescaled count", tc, PRE_TAB[k][2]);
    end
    // R11 count has passed every channel value of 0 with controls at 0
    chk("R11 no flags", {26'b0, irq}, 0);
    chk("R11 still running", {31'b0, run}, 1);

    // R5 / R3 halt with flag on channel 0
    halt_at(5);
    chk("R5 frozen count", tc, 5);
    chk("R5 run cleared", {31'b0, run}, 0);
    chk("R3 flag set", {31'b0, irq[0]}, 1);
    wait_clk(10);
    chk("R5 stays frozen", tc, 5);
    chk("R3 flag sticky", {31'b0, irq[0]}, 1);
    wr(A_ICLR, 1);
    chk("R3 flag cleared", {31'b0, irq[0]}, 0);

    // R4 clear-count on channel 1, no flag bit
    wr(A_CTRL, 2);
    wr(A_M0 + 1, 3);
    wr(A_MCTL, 32'h10);
    wr(A_CTRL, 1);
    mx = 0;
    for (int c = 0; c < 20; c++) begin
      wait_clk(1);
      if (int'(tc) > mx) mx = int'(tc);
    end
    chk("R4 max count", mx, 3);
    chk("R3 no flag without bit", {31'b0, irq[1]}, 0);

    // R6 clear on ch2 and halt on ch3 at the same value
    wr(A_CTRL, 2);
    wr(A_ICLR, 32'h3F);
    wr(A_M0 + 2, 7);
    wr(A_M0 + 3, 7);
    wr(A_MCTL, (3 << 6) | (5 << 9));
    wr(A_CTRL, 1);
    wait_clk(20);
    chk("R6 count zero", tc, 0);
    chk("R6 run cleared", {31'b0, run}, 0);
    chk("R6 both flags", {30'b0, irq[3:2]}, 3);

    // R7 / R10 rising capture with flag on input 0
    wr(A_ICLR, 32'h3F);
    halt_at(9);
    wr(A_CCTL, 5);
    cap[0] = 1'b1;
    wait_clk(5);
    chk("R7 rising capture", cap_val[31:0], 9);
    chk("R10 capture flag", {31'b0, irq[4]}, 1);

    // R8 falling edge ignored on rising-only input
    halt_at(12);
    wr(A_ICLR, 32'h3F);
    cap[0] = 1'b0;
    wait_clk(5);
    chk("R8 fall ignored", cap_val[31:0], 9);
    chk("R10 no flag on ignored edge", {31'b0, irq[4]}, 0);

    // R8 / R10 falling-only input 1 without flag
    wr(A_CCTL, 32'h10);
    cap[1] = 1'b1;
    wait_clk(5);
    chk("R8 rise ignored", cap_val[63:32], 0);
    cap[1] = 1'b0;
    wait_clk(5);
    chk("R8 falling capture", cap_val[63:32], 12);
    chk("R10 flag bit off", {31'b0, irq[5]}, 0);

    // R9 both edges on input 0
    wr(A_CCTL, 3);
    halt_at(20);
    cap[0] = 1'b1;
    wait_clk(5);
    chk("R9 rise captured", cap_val[31:0], 20);
    halt_at(25);
    cap[0] = 1'b0;
    wait_clk(5);
    chk("R9 fall captured", cap_val[31:0], 25);

    // R12 hold-clear wins over run
    wr(A_MCTL, 0);
    wr(A_CTRL, 3);
    wait_clk(10);
    chk("R12 count held", tc, 0);
    chk("R12 run set", {31'b0, run}, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule